// File: doc/BRIEF.md
# Chip Power-Down and Reset Sequencer

This block decides which parts of a mixed-signal signal-processing chip may run. It watches an active-low power-down pin, a supply-good indication and a clock-stable indication, and holds five software-controlled reset bits: one that releases the clock generator and four that release the hub, the converter group and two DSP cores. From these it derives one of four chip-level states, ordered strictly: pin power-down, clock reset, system reset, running. It then drives the enables and active-low resets of the downstream blocks to match.

The pin goes through a two-flop synchronizer. The pin is masked until the supplies have been good for a minimum settling time. Once the pin is released, register writes are refused until a second, longer interval has elapsed, and a ready flag shows when that interval is over. Both intervals are given in nanoseconds and are converted to cycle counts from the reference clock frequency parameter. Dropping the pin clears every reset bit and restarts the write window.

Top module: `pwr_seq_top`

## Requirements
- R1: While the effective pin is low (synchronized pin low, or supplies not yet settled), `state_o` is 00 and every output (reference enable, PLL enable, all four reset releases, converter and rate-converter enables, ready) is 0.
- R2: With the effective pin high and the clock bit at 0, `state_o` is 01, `ref_en_o` is 1, and the PLL enable and all block outputs are 0, whatever the other four bits hold.
- R3: With the effective pin high, the clock bit at 1 and the hub, codec and both DSP bits at 0, `state_o` is 10, `pll_en_o` is 1 and every block output stays 0.
- R4: Setting any one of the hub, codec, DSP1 or DSP2 bits while the clock bit is 1 gives `state_o` 11. Clearing all four returns the state to 10.
- R5: In the running state each reset release follows its own bit. `conv_en_o` equals the codec bit, and `src_en_o` equals the hub bit.
- R6: `reg_ready_o` rises only after the effective pin has been high for REG_WAIT_NS worth of clock cycles. A write presented while it is 0 changes nothing.
- R7: The pin is masked until `supply_good_i` has been high for SUPPLY_WAIT_NS worth of cycles. Dropping `supply_good_i` masks the pin again from the next edge.
- R8: A write that would set the clock bit from 0 to 1 while `clk_stable_i` is 0 leaves the clock bit at 0. The other four bits of that write are still stored.
- R9: When the effective pin falls, all five bits clear to 0 and the write window restarts. After the pin is raised again the state is 01 and ready stays 0 for the full interval.
- R10: A change on `pdn_ni` reaches `state_o` at the second rising clock edge, not at the first.
- R11: Write data layout: bit 4 is the clock bit, bit 3 the hub bit, bit 2 the codec bit, bit 1 DSP1 and bit 0 DSP2. An accepted write replaces all five bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low reset of the controller itself |
| supply_good_i | input | 1 | All supplies within range |
| pdn_ni | input | 1 | Active-low power-down pin, asynchronous |
| clk_stable_i | input | 1 | Clock source is stable |
| wr_en_i | input | 1 | Write strobe for the reset bits |
| wr_data_i | input | 5 | New reset bit values (layout in R11) |
| ref_en_o | output | 1 | Analog reference and internal supply enable |
| reg_ready_o | output | 1 | Register writes are being accepted |
| state_o | output | 2 | Chip state: 00 off, 01 clock reset, 10 system reset, 11 running |
| pll_en_o | output | 1 | PLL and internal clock enable |
| hub_rst_no | output | 1 | Hub reset, active low |
| dsp1_rst_no | output | 1 | DSP core 1 reset, active low |
| dsp2_rst_no | output | 1 | DSP core 2 reset, active low |
| codec_rst_no | output | 1 | Codec reset, active low |
| conv_en_o | output | 1 | ADC/DAC run enable |
| src_en_o | output | 1 | Sample-rate converter run enable |

## Verification
A corrupted reset bit shows up on `state_o` and on one block's reset release in the cycle after the write edge, because the outputs are decoded combinationally from the registered bits. A write-window counter that runs short or long moves the rise of `reg_ready_o` away from its expected cycle. It also makes an early write take effect, which is visible one edge later. A fault in the synchronizer or the supply mask shifts the cycle in which `state_o` leaves or enters 00, and that shift appears within a handful of edges of the pin or supply change.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_CLKRST = 2'b01,
        ST_SYSRST = 2'b10,
        ST_RUN    = 2'b11
    } chip_state_e;

    // Field order matches the write data layout, MSB first.
    typedef struct packed {
        logic clk_on;
        logic hub;
        logic codec;
        logic dsp1;
        logic dsp2;
    } rst_bits_t;

    localparam int unsigned RST_BITS_W = $bits(rst_bits_t);

    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned khz);
        logic [63:0] prod;
        logic [63:0] cyc;
        prod = 64'(ns) * 64'(khz);
        cyc  = (prod + 64'd999_999) / 64'd1_000_000;
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc[31:0]);
    endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int unsigned LIMIT = 60,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)                   cnt_d = '0;
        else if (cnt_q != CW'(LIMIT)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == CW'(LIMIT));

    // Counter saturates at the limit and never wraps (R6, R7).
    p_cnt_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(LIMIT));
    // Dropping the run input always restarts the interval (R9).
    p_restart_on_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !done_o);
endmodule

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode
    import pwr_seq_pkg::*;
(
    input  logic        pin_on_i,
    input  rst_bits_t   bits_i,
    output chip_state_e state_o,
    output logic        ref_en_o,
    output logic        pll_en_o,
    output logic        hub_rst_no,
    output logic        dsp1_rst_no,
    output logic        dsp2_rst_no,
    output logic        codec_rst_no,
    output logic        conv_en_o,
    output logic        src_en_o
);
    logic any_block;
    logic running;

    always_comb begin
        any_block = bits_i.hub | bits_i.codec | bits_i.dsp1 | bits_i.dsp2;
        if (!pin_on_i)          state_o = ST_OFF;
        else if (!bits_i.clk_on) state_o = ST_CLKRST;
        else if (!any_block)    state_o = ST_SYSRST;
        else                    state_o = ST_RUN;

        running      = (state_o == ST_RUN);
        ref_en_o     = pin_on_i;
        pll_en_o     = (state_o == ST_SYSRST) || running;
        hub_rst_no   = running & bits_i.hub;
        dsp1_rst_no  = running & bits_i.dsp1;
        dsp2_rst_no  = running & bits_i.dsp2;
        codec_rst_no = running & bits_i.codec;
        conv_en_o    = running & bits_i.codec;
        src_en_o     = running & bits_i.hub;
    end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CLK_FREQ_KHZ   = 100_000,
    parameter int unsigned SUPPLY_WAIT_NS = 600,
    parameter int unsigned REG_WAIT_NS    = 1_000_000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_good_i,
    input  logic       pdn_ni,
    input  logic       clk_stable_i,
    input  logic       wr_en_i,
    input  logic [4:0] wr_data_i,
    output logic       ref_en_o,
    output logic       reg_ready_o,
    output logic [1:0] state_o,
    output logic       pll_en_o,
    output logic       hub_rst_no,
    output logic       dsp1_rst_no,
    output logic       dsp2_rst_no,
    output logic       codec_rst_no,
    output logic       conv_en_o,
    output logic       src_en_o
);
    localparam int unsigned SUP_CYC = ns_to_cycles(SUPPLY_WAIT_NS, CLK_FREQ_KHZ);
    localparam int unsigned REG_CYC = ns_to_cycles(REG_WAIT_NS, CLK_FREQ_KHZ);

    logic        pdn_s;
    logic        sup_done;
    logic        reg_done;
    logic        pin_on;
    logic        wr_ok;
    rst_bits_t   bits_d, bits_q;
    rst_bits_t   wr_bits;
    chip_state_e state_e;

    pwr_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pdn_ni),
        .q_o   (pdn_s)
    );

    pwr_seq_timer #(.LIMIT(SUP_CYC)) u_supply_tmr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (supply_good_i),
        .done_o(sup_done)
    );

    assign pin_on = pdn_s & sup_done;

    pwr_seq_timer #(.LIMIT(REG_CYC)) u_reg_tmr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (pin_on),
        .done_o(reg_done)
    );

    assign reg_ready_o = reg_done & pin_on;

    always_comb begin
        wr_bits = rst_bits_t'(wr_data_i);
        wr_ok   = wr_en_i & reg_ready_o;
        bits_d  = bits_q;
        if (!pin_on) begin
            bits_d = '0;
        end else if (wr_ok) begin
            bits_d = wr_bits;
            if (wr_bits.clk_on && !bits_q.clk_on && !clk_stable_i)
                bits_d.clk_on = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bits_q <= '0;
        else         bits_q <= bits_d;
    end

    pwr_seq_decode u_decode (
        .pin_on_i    (pin_on),
        .bits_i      (bits_q),
        .state_o     (state_e),
        .ref_en_o    (ref_en_o),
        .pll_en_o    (pll_en_o),
        .hub_rst_no  (hub_rst_no),
        .dsp1_rst_no (dsp1_rst_no),
        .dsp2_rst_no (dsp2_rst_no),
        .codec_rst_no(codec_rst_no),
        .conv_en_o   (conv_en_o),
        .src_en_o    (src_en_o)
    );

    assign state_o = state_e;

    // R1: the off state silences every downstream output.
    p_off_all_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b00) |-> !(ref_en_o | pll_en_o | hub_rst_no | dsp1_rst_no |
                                 dsp2_rst_no | codec_rst_no | conv_en_o | src_en_o | reg_ready_o));
    // R2: no PLL and no block runs while the clock bit is low.
    p_clkrst_no_pll_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bits_q.clk_on |-> !pll_en_o && (state_o != 2'b11));
    // R3: system reset keeps every block in reset.
    p_sysrst_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b10) |-> !(hub_rst_no | dsp1_rst_no | dsp2_rst_no | codec_rst_no));
    // R6: no write lands before the window has elapsed.
    p_no_early_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !reg_ready_o |=> (bits_q == '0));
    // R6: ready is never shown without the pin released.
    p_ready_needs_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_ready_o |-> ref_en_o);
    // R7: supplies not settled keeps the chip off.
    p_supply_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_good_i |=> (state_o == 2'b00));
    // R8: the clock bit only rises with a stable clock.
    p_clk_needs_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bits_q.clk_on) |-> $past(clk_stable_i));
    // R9: losing the pin clears the bits at the next edge.
    p_pin_loss_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pin_on |=> (bits_q == '0));
endmodule

// File: tb/tb_pwr_seq_top.sv
module tb_pwr_seq_top;
    localparam int unsigned REG_CYC = 200; // 2000 ns at 100 MHz
    localparam int unsigned SUP_CYC = 60;  // 600 ns at 100 MHz

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_good, pdn_n, clk_stable, wr_en;
    logic [4:0] wr_data;
    logic       ref_en, reg_ready, pll_en, hub_rn, d1_rn, d2_rn, codec_rn, conv_en, src_en;
    logic [1:0] state;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwr_seq_top #(.CLK_FREQ_KHZ(100_000), .SUPPLY_WAIT_NS(600), .REG_WAIT_NS(2000)) dut (
        .clk_i(clk), .rst_ni(rst_n), .supply_good_i(supply_good), .pdn_ni(pdn_n),
        .clk_stable_i(clk_stable), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .ref_en_o(ref_en), .reg_ready_o(reg_ready), .state_o(state), .pll_en_o(pll_en),
        .hub_rst_no(hub_rn), .dsp1_rst_no(d1_rn), .dsp2_rst_no(d2_rn),
        .codec_rst_no(codec_rn), .conv_en_o(conv_en), .src_en_o(src_en)
    );

    function automatic logic [7:0] outs();
        return {pll_en, hub_rn, d1_rn, d2_rn, codec_rn, conv_en, src_en, reg_ready};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write(input logic [4:0] d);
        wr_en = 1'b1; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 reset state", {30'd0, state}, 32'd0);
        chk("R1 reset outputs", {23'd0, ref_en, outs()}, 32'd0);
    endtask

    task automatic t_supply_mask();
        tick(50);
        chk("R7 pin masked without supply", {30'd0, state}, 32'd0);
        supply_good = 1'b1;
        tick(SUP_CYC - 2);
        chk("R7 still masked before settle", {30'd0, state}, 32'd0);
        tick(3);
        chk("R7 released after settle", {30'd0, state}, 32'd1);
        chk("R2 ref enabled", {31'd0, ref_en}, 32'd1);
    endtask

    task automatic t_reg_window();
        clk_stable = 1'b1;
        write(5'b11111);
        chk("R6 early write ignored state", {30'd0, state}, 32'd1);
        chk("R6 early write ignored outs", {24'd0, outs()}, 32'd0);
        tick(REG_CYC - 10);
        chk("R6 ready low inside window", {31'd0, reg_ready}, 32'd0);
        tick(12);
        chk("R6 ready high after window", {31'd0, reg_ready}, 32'd1);
    endtask

    task automatic t_clock_gate();
        clk_stable = 1'b0;
        write(5'b10000);
        chk("R8 clock bit refused", {30'd0, state}, 32'd1);
        write(5'b10100);
        chk("R8 others stored, still clk reset", {30'd0, state}, 32'd1);
        chk("R2 codec held while clk reset", {30'd0, conv_en, codec_rn}, 32'd0);
        clk_stable = 1'b1;
        write(5'b10000);
        chk("R3 system reset state", {30'd0, state}, 32'd2);
        chk("R3 pll on, blocks idle", {24'd0, outs()}, 32'h81);
    endtask

    task automatic t_run_each();
        for (int i = 0; i < 4; i++) begin
            logic [4:0] d;
            logic [7:0] exp;
            d = 5'b10000 | 5'(1 << i);
            write(d);
            chk("R4 any bit runs", {30'd0, state}, 32'd3);
            exp = 8'h81;
            if (d[3]) exp |= 8'b0100_0010; // hub + src
            if (d[2]) exp |= 8'b0000_1100; // codec + conv
            if (d[1]) exp |= 8'b0010_0000;
            if (d[0]) exp |= 8'b0001_0000;
            chk("R5 per-block follow, R11 layout", {24'd0, outs()}, {24'd0, exp});
        end
        write(5'b10000);
        chk("R4 all clear back to sysrst", {30'd0, state}, 32'd2);
        write(5'b01111);
        chk("R2 clock bit low dominates", {30'd0, state}, 32'd1);
        chk("R2 outputs off in clk reset", {24'd0, outs()}, 32'h01);
    endtask

    task automatic t_pdn_drop();
        write(5'b11111);
        chk("R4 all running", {30'd0, state}, 32'd3);
        pdn_n = 1'b0;
        tick(1);
        chk("R10 one edge not yet seen", {30'd0, state}, 32'd3);
        tick(1);
        chk("R10 seen at second edge", {30'd0, state}, 32'd0);
        chk("R1 all off on pin low", {23'd0, ref_en, outs()}, 32'd0);
        tick(3);
        pdn_n = 1'b1;
        tick(2);
        chk("R9 bits cleared after pin drop", {30'd0, state}, 32'd1);
        tick(REG_CYC - 10);
        chk("R9 window restarted", {31'd0, reg_ready}, 32'd0);
        tick(12);
        chk("R9 ready after restart", {31'd0, reg_ready}, 32'd1);
        supply_good = 1'b0;
        tick(1);
        chk("R7 supply loss masks pin", {30'd0, state}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; supply_good = 1'b0; pdn_n = 1'b1;
        clk_stable = 1'b0; wr_en = 1'b0; wr_data = '0;
        tick(5);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_supply_mask();
        t_reg_window();
        t_clock_gate();
        t_run_each();
        t_pdn_drop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule